// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the protection state of a 1M x 8 serial flash and decides, for every write-type command, whether it may proceed. The command decoder presents one-cycle strobes for write-enable, write-disable, status-register write, page program, sector erase, block erase and chip erase. It also supplies a 20-bit byte address, a status data byte and the level of the active-low write-protect pin. One clock after each strobe the block returns a one-cycle grant or a one-cycle reject. The program/erase engine acts only on a grant, so a rejected command leaves the array as it was.

The protected region is always an upper slice of the array. A 3-bit protection code picks that slice: nothing, the top 1/16, 1/8, 1/4 or 1/2, or the whole array. A lock bit freezes the code and the lock bit itself, but only while the write-protect pin is held low. Chip erase is refused whenever any bit of the code is set. The status byte is always readable and reflects the busy input, the write-enable latch, the code and the lock bit.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the protection code is 111, the lock bit is 0 and the write-enable latch is 0, so the status byte reads 0x1C while busy is low.
- R2: The status byte has busy in bit 0, the write-enable latch in bit 1, the protection code (LSB first) in bits 2 to 4, zeros in bits 5 and 6, and the lock bit in bit 7.
- R3: Every command strobe produces exactly one cycle of grant or of reject, in the cycle after the strobe. Neither output pulses when no strobe is present.
- R4: Write-enable is always granted and sets the latch. Write-disable is always granted and clears the latch.
- R5: Status write, program and erase commands are rejected while the latch is 0. Each of them clears the latch, whether it is granted or rejected.
- R6: A status write with the latch set and with the pin high or the lock bit 0 is granted. It loads the code from data bits 4:2 and the lock bit from data bit 7.
- R7: With the pin low and the lock bit 1, a status write is rejected and the code and lock bit keep their values.
- R8: The code selects the protected range: 000 none, 001 F0000h-FFFFFh, 010 E0000h-FFFFFh, 011 C0000h-FFFFFh, 100 80000h-FFFFFh, and 101, 110 or 111 the whole array. A program or erase whose checked address falls inside the range is rejected.
- R9: Page program checks the supplied address. Sector erase checks that address rounded down to 4 KB, and block erase checks it rounded down to 64 KB.
- R10: Chip erase is granted only when the latch is set and the code is 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-register write strobe |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Block erase strobe |
| cmd_ce | input | 1 | Chip erase strobe |
| addr | input | 20 | Byte address of program or erase |
| sr_wdata | input | 8 | Data byte for status write |
| wp_n | input | 1 | Write-protect pin level, low asserts |
| busy | input | 1 | Busy flag shown in status bit 0 |
| grant | output | 1 | Command accepted pulse |
| reject | output | 1 | Command refused pulse |
| status | output | 8 | Status byte |

## Verification
A corrupted protection code or lock bit appears on the status byte in the cycle after the status write that caused it. It also flips the grant/reject answer of the very next program or erase near a range boundary, one clock after that strobe. A stuck write-enable latch shows in status bit 1 and turns the following write-class command into a wrong answer. Sweeping every code against every 64 KB block for all three address-based commands exposes an off-by-one range edge or a misapplied alignment within a single command.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W   = 20,
  parameter int SECTOR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_ce,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  input  logic              busy,
  output logic              grant,
  output logic              reject,
  output logic [7:0]        status
);
  localparam int BLOCK_W = ADDR_W - 4;
  localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(1) << ADDR_W;

  logic [2:0] bp;
  logic bpl, wel, grant_q, reject_q;

  wire mem_cmd  = cmd_pp | cmd_se | cmd_be | cmd_ce;
  wire wr_class = mem_cmd | cmd_wrsr;
  wire any_cmd  = wr_class | cmd_wren | cmd_wrdi;
  wire sr_open  = wp_n | ~bpl;
  wire sel_wrsr = cmd_wrsr & ~mem_cmd;
  wire unused_data = ^{sr_wdata[6:5], sr_wdata[1:0]};

  logic [ADDR_W-1:0] chk_addr;
  logic [ADDR_W:0]   prot_size;
  logic              in_prot, ok;

  always_comb begin
    chk_addr = addr;
    if (cmd_be)      chk_addr[BLOCK_W-1:0]  = '0;
    else if (cmd_se) chk_addr[SECTOR_W-1:0] = '0;
  end

  always_comb begin
    case (bp)
      3'd0:    prot_size = '0;
      3'd1, 3'd2, 3'd3, 3'd4:
               prot_size = (ADDR_W+1)'(1) << (BLOCK_W + int'(bp) - 1);
      default: prot_size = FULL;
    endcase
  end

  assign in_prot = {1'b0, chk_addr} >= (FULL - prot_size);

  always_comb begin
    if (cmd_ce)                        ok = wel & (bp == 3'd0);
    else if (cmd_be | cmd_se | cmd_pp) ok = wel & ~in_prot;
    else if (cmd_wrsr)                 ok = wel & sr_open;
    else                               ok = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp       <= 3'b111;
      bpl      <= 1'b0;
      wel      <= 1'b0;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= any_cmd & ok;
      reject_q <= any_cmd & ~ok;
      if (wr_class | cmd_wrdi) wel <= 1'b0;
      else if (cmd_wren)       wel <= 1'b1;
      if (sel_wrsr & wel & sr_open) begin
        bp  <= sr_wdata[4:2];
        bpl <= sr_wdata[7];
      end
    end
  end

  assign grant  = grant_q;
  assign reject = reject_q;
  assign status = {bpl, 2'b00, bp, wel, busy};

  assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> (grant ^ reject));
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> (!grant && !reject));
  assert_wel_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_class |=> !status[1]);
  assert_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_class && !status[1]) |=> reject);
  assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && status[7]) |=> ($stable(status[4:2]) && status[7]));
  assert_ce_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ce && status[4:2] != 3'd0) |=> reject);
endmodule

// File: tb/test_flash_wp_ctrl.sv
`timescale 1ns/1ps
module test_flash_wp_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] cmds = '0;
  logic [19:0] addr = '0;
  logic [7:0] sr_wdata = '0;
  logic wp_n = 1'b1, busy = 1'b0;
  logic grant, reject;
  logic [7:0] status;
  int checks = 0, errors = 0;
  logic g, r;

  always #10 clk = ~clk;

  flash_wp_ctrl i_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wren(cmds[0]), .cmd_wrdi(cmds[1]), .cmd_wrsr(cmds[2]),
    .cmd_pp(cmds[3]), .cmd_se(cmds[4]), .cmd_be(cmds[5]), .cmd_ce(cmds[6]),
    .addr(addr), .sr_wdata(sr_wdata), .wp_n(wp_n), .busy(busy),
    .grant(grant), .reject(reject), .status(status));

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // idx: 0 wren, 1 wrdi, 2 wrsr, 3 pp, 4 se, 5 be, 6 ce
  task automatic issue(input int idx, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    cmds = 7'(1) << idx; addr = a; sr_wdata = d;
    @(negedge clk);
    cmds = '0;
    g = grant; r = reject;
    check(g ^ r, "R3 one result", {g, r}, 1);
    @(negedge clk);
    check(!grant && !reject, "R3 single cycle", {grant, reject}, 0);
  endtask

  task automatic set_code(input logic [2:0] c, input logic lk);
    issue(0, '0, '0);
    issue(2, '0, {lk, 2'b00, c, 2'b00});
    check(g, "R6 status write granted", g, 1);
    check(status == {lk, 2'b00, c, 2'b00}, "R6 fields loaded", status, {lk, 2'b00, c, 2'b00});
  endtask

  function automatic logic prot(input int code, input int a);
    int lim;
    if (code == 0) lim = 1 << 20;
    else if (code >= 5) lim = 0;
    else lim = (1 << 20) - (1 << (15 + code));
    return a >= lim;
  endfunction

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h1C, "R1 reset status", status, 8'h1C);
    check(!grant && !reject, "R3 idle no pulse", {grant, reject}, 0);
    busy = 1'b1; #1;
    check(status == 8'h1D, "R2 busy in bit 0", status, 8'h1D);
    busy = 1'b0;

    issue(2, '0, 8'h00);
    check(r, "R5 status write without latch", r, 1);
    check(status == 8'h1C, "R5 fields kept", status, 8'h1C);
    issue(3, 20'h00000, '0);
    check(r, "R5 program without latch", r, 1);

    issue(0, '0, '0);
    check(g && status[1], "R4 write-enable", {g, status[1]}, 3);
    issue(1, '0, '0);
    check(g && !status[1], "R4 write-disable", {g, status[1]}, 2);

    for (int c = 0; c < 8; c++) begin
      set_code(3'(c), 1'b0);
      for (int n = 0; n < 16; n++) begin
        for (int k = 3; k <= 5; k++) begin
          int a;
          a = (n << 16) | ((k == 3) ? 16'h0000 : 16'hFFFF);
          issue(0, '0, '0);
          issue(k, 20'(a), '0);
          if (k == 3) check(g == !prot(c, a), "R8 page program range", g, !prot(c, a));
          else        check(g == !prot(c, a & ((k == 4) ? 32'hFF000 : 32'hF0000)),
                            "R9 aligned erase range", g, !prot(c, a));
          check(!status[1], "R5 latch cleared", status[1], 0);
        end
      end
      issue(0, '0, '0);
      issue(6, '0, '0);
      check(g == (c == 0), "R10 chip erase", g, c == 0);
    end

    set_code(3'd3, 1'b1);
    wp_n = 1'b0;
    issue(0, '0, '0);
    issue(2, '0, 8'h00);
    check(r, "R7 locked write rejected", r, 1);
    check(status == 8'h8C, "R7 fields frozen", status, 8'h8C);
    issue(3, 20'hC0000, '0);
    check(r, "R7 range still 011", r, 1);
    wp_n = 1'b1;
    set_code(3'd0, 1'b0);
    issue(0, '0, '0);
    issue(6, '0, '0);
    check(g, "R10 chip erase after unlock", g, 1);
    wp_n = 1'b0;
    set_code(3'd1, 1'b0);
    wp_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule